// File: doc/BRIEF.md
# ATM Cell Header Checker with Single-Bit Repair

This block sits on the receive side of an ATM cell path. Once cell boundaries are known, it takes cells one byte per clock. A start marker flags the first byte of each 53-byte cell. The block computes the header check byte over the first four header bytes and compares it with the fifth byte. It repairs any header that carries exactly one flipped bit. It throws away every cell whose header damage cannot be repaired, and every idle cell.

Each cell is held in one of two cell-sized buffers until its last byte has arrived. The cell is then copied to a receive-FIFO write port as one unbroken burst. A truncated or dropped cell therefore never leaves a fragment in the FIFO. Three wrapping counters report accepted cells, cells dropped for header errors, and idle cells dropped.

Top module: `hec_cell_filter`

## Requirements
- R1: The check byte is a CRC-8 over header bytes 0..3. Bytes are taken in arrival order, each most significant bit first. The generator is x^8+x^2+x+1, the register starts at zero, and the result is XORed with 0x55. A cell whose fifth byte equals this value is forwarded with all 53 bytes unchanged.
- R2: The 40 header bits are numbered 39 (MSB of byte 0) down to 0 (LSB of the check byte). When any single one of them is inverted, the cell is forwarded with the header restored, check byte included.
- R3: A cell whose syndrome is non-zero and matches none of the 40 single-bit syndromes is discarded whole and increments `cnt_err_drop` by one. Any two-bit header error falls in this class.
- R4: A cell whose header, after repair, reads 00 00 00 01 in bytes 0..3 is discarded whole and increments `cnt_idle_drop`; any other header value is not idle.
- R5: A forwarded cell appears as 53 consecutive cycles of `wr_en`, with `wr_sop` on the first and `wr_eop` on the last. Payload bytes are unchanged and cells keep their arrival order. Input cells arriving back to back with no gap are all forwarded.
- R6: All counters and `wr_en` are zero after reset. `cnt_good` increments by one in the same cycle that `wr_eop` is shown, and counters wrap at 2^CNT_W.
- R7: No byte of a cell reaches the write port before its last byte is accepted. The first byte appears in the clock after the edge that accepts the last byte, provided the port is idle.
- R8: Valid bytes that arrive outside a cell are ignored. A cell cut short by a new start marker is discarded without changing any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a cell |
| in_data | input | 8 | Input byte |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write byte |
| wr_sop | output | 1 | Written byte is the first of a cell |
| wr_eop | output | 1 | Written byte is the last of a cell |
| cnt_good | output | CNT_W | Cells written to the FIFO |
| cnt_err_drop | output | CNT_W | Cells dropped for uncorrectable header |
| cnt_idle_drop | output | CNT_W | Idle cells dropped |

## Verification
A wrong running CRC or a wrong syndrome entry shows up as a header byte that differs from the clean header. It can also show up as a wrongly counted drop, within one cell time of the cell's last byte. A stale buffer-ready flag or read pointer shows as a burst shorter or longer than 53 bytes. It can also show as a repeated or missing cell, or as a first byte one or more clocks late. The bench therefore checks framing on every burst, checks the exact start cycle, and covers all 40 single-bit positions, back-to-back cells and a truncated cell.

// File: rtl/hec_pkg.sv
package hec_pkg;

   localparam int HDR_BYTES = 5;
   localparam int HDR_BITS  = 8 * HDR_BYTES;
   localparam logic [7:0]  HEC_POLY  = 8'h07;
   localparam logic [7:0]  HEC_COSET = 8'h55;
   localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;

   typedef enum logic [1:0] {
      CLS_PASS = 2'd0,
      CLS_IDLE = 2'd1,
      CLS_ERR  = 2'd2
   } cell_class_e;

   // One byte through the CRC-8 register, most significant bit first.
   function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] d);
      logic [7:0] c;
      logic       fb;
      c = crc_in;
      for (int b = 7; b >= 0; b--) begin
         fb = c[7] ^ d[b];
         c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
      end
      return c;
   endfunction

   // CRC-8 of four header bytes, byte 0 in bits 31:24.
   function automatic logic [7:0] crc8_word(input logic [31:0] w);
      logic [7:0] c;
      c = 8'h00;
      for (int i = 3; i >= 0; i--) c = crc8_byte(c, w[i*8 +: 8]);
      return c;
   endfunction

   // Syndrome left by one inverted bit; p = 39 is MSB of byte 0, p = 0 is LSB of the check byte.
   function automatic logic [7:0] single_bit_syndrome(input int p);
      logic [7:0]  s;
      logic [31:0] w;
      s = 8'h00;
      w = 32'h0;
      if (p < 8) begin
         s[p] = 1'b1;
      end else begin
         w[p-8] = 1'b1;
         s = crc8_word(w);
      end
      return s;
   endfunction

endpackage

// File: rtl/hec_crc_accum.sv
module hec_crc_accum
   import hec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       first,
   input  logic [7:0] data,
   output logic [7:0] crc
);

   logic [7:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc_q <= 8'h00;
      else if (en) crc_q <= crc8_byte(first ? 8'h00 : crc_q, data);
   end

   assign crc = crc_q;

endmodule

// File: rtl/hec_corrector.sv
module hec_corrector
   import hec_pkg::*;
#(
   parameter bit CORRECT_EN = 1'b1
)
(
   input  logic [31:0] hdr_rx,
   input  logic [7:0]  hec_rx,
   input  logic [7:0]  crc_calc,
   output logic [31:0] hdr_fix,
   output logic [7:0]  hec_fix,
   output logic        hdr_bad
);

   logic [7:0]          syndrome;
   logic [HDR_BITS-1:0] flip;

   assign syndrome = crc_calc ^ HEC_COSET ^ hec_rx;

   generate
      if (CORRECT_EN) begin : g_repair
         for (genvar p = 0; p < HDR_BITS; p++) begin : g_pos
            localparam logic [7:0] SYN = single_bit_syndrome(p);
            assign flip[p] = (syndrome == SYN);
         end
      end else begin : g_detect_only
         assign flip = '0;
      end
   endgenerate

   assign {hdr_fix, hec_fix} = {hdr_rx, hec_rx} ^ flip;
   assign hdr_bad = (syndrome != 8'h00) && (flip == '0);

endmodule

// File: rtl/hec_cell_store.sv
module hec_cell_store
   import hec_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int NUM_BUF    = 2,
   parameter int ADDR_W     = $clog2(CELL_BYTES),
   parameter int BUF_W      = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
)
(
   input  logic                clk,
   input  logic                wr_en,
   input  logic [BUF_W-1:0]    wr_buf,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [7:0]          wr_byte,
   input  logic                hdr_load,
   input  logic [HDR_BITS-1:0] hdr_word,
   input  logic [BUF_W-1:0]    rd_buf,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [7:0]          rd_byte
);

   logic [7:0] buf_rd [NUM_BUF];

   generate
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
         logic [7:0] cells [CELL_BYTES];
         always_ff @(posedge clk) begin
            if (wr_en && wr_buf == BUF_W'(b)) cells[wr_addr] <= wr_byte;
            if (hdr_load && wr_buf == BUF_W'(b)) begin
               for (int k = 0; k < HDR_BYTES; k++) cells[k] <= hdr_word[HDR_BITS-1-8*k -: 8];
            end
         end
         assign buf_rd[b] = cells[rd_addr];
      end
   endgenerate

   assign rd_byte = buf_rd[rd_buf];

endmodule

// File: rtl/hec_cell_filter.sv
module hec_cell_filter
   import hec_pkg::*;
#(
   parameter int CELL_BYTES = 53,
   parameter int CNT_W      = 16,
   parameter bit CORRECT_EN = 1'b1
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [7:0]       in_data,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic             wr_sop,
   output logic             wr_eop,
   output logic [CNT_W-1:0] cnt_good,
   output logic [CNT_W-1:0] cnt_err_drop,
   output logic [CNT_W-1:0] cnt_idle_drop
);

   localparam int ADDR_W  = $clog2(CELL_BYTES);
   localparam int NUM_BUF = 2;
   localparam int BUF_W   = 1;
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(CELL_BYTES - 1);
   localparam logic [ADDR_W-1:0] HEC_IDX  = ADDR_W'(HDR_BYTES - 1);

   generate
      if (CELL_BYTES <= HDR_BYTES) begin : g_bad_cell_len
         $error("CELL_BYTES must exceed the header length");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("CNT_W must be at least 1");
      end
   endgenerate

   // ---------------- intake ----------------
   logic              in_cell_q;
   logic [ADDR_W-1:0] idx_q, pos;
   logic              take, hdr_end, cell_end, crc_en;
   logic [31:0]       hdr_q;
   logic [7:0]        crc_calc;
   logic [31:0]       hdr_fix;
   logic [7:0]        hec_fix;
   logic              hdr_bad;
   cell_class_e       class_d, class_q;
   logic [BUF_W-1:0]  wb_q;

   assign take     = in_valid && (in_sop || in_cell_q);
   assign pos      = in_sop ? '0 : idx_q;
   assign hdr_end  = take && (pos == HEC_IDX);
   assign cell_end = take && (pos == LAST_IDX);
   assign crc_en   = take && (pos < HEC_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else if (crc_en) begin
         for (int k = 0; k < 4; k++) begin
            if (pos == ADDR_W'(k)) hdr_q[31-8*k -: 8] <= in_data;
         end
      end
   end

   hec_crc_accum u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (crc_en),
      .first (pos == '0),
      .data  (in_data),
      .crc   (crc_calc)
   );

   hec_corrector #(.CORRECT_EN(CORRECT_EN)) u_fix (
      .hdr_rx   (hdr_q),
      .hec_rx   (in_data),
      .crc_calc (crc_calc),
      .hdr_fix  (hdr_fix),
      .hec_fix  (hec_fix),
      .hdr_bad  (hdr_bad)
   );

   always_comb begin
      if (hdr_bad)                    class_d = CLS_ERR;
      else if (hdr_fix == IDLE_HDR)   class_d = CLS_IDLE;
      else                            class_d = CLS_PASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cell_q     <= 1'b0;
         idx_q         <= '0;
         class_q       <= CLS_PASS;
         wb_q          <= '0;
         cnt_err_drop  <= '0;
         cnt_idle_drop <= '0;
      end else begin
         if (take) begin
            in_cell_q <= (pos != LAST_IDX);
            idx_q     <= pos + 1'b1;
         end
         if (hdr_end) class_q <= class_d;
         if (cell_end) begin
            case (class_q)
               CLS_PASS: wb_q          <= ~wb_q;
               CLS_ERR:  cnt_err_drop  <= cnt_err_drop + 1'b1;
               CLS_IDLE: cnt_idle_drop <= cnt_idle_drop + 1'b1;
               default:  ;
            endcase
         end
      end
   end

   // ---------------- storage ----------------
   logic [BUF_W-1:0]  rb_q;
   logic [ADDR_W-1:0] ridx_q;
   logic [7:0]        rd_byte;

   hec_cell_store #(
      .CELL_BYTES (CELL_BYTES),
      .NUM_BUF    (NUM_BUF),
      .ADDR_W     (ADDR_W),
      .BUF_W      (BUF_W)
   ) u_store (
      .clk      (clk),
      .wr_en    (take),
      .wr_buf   (wb_q),
      .wr_addr  (pos),
      .wr_byte  (in_data),
      .hdr_load (hdr_end),
      .hdr_word ({hdr_fix, hec_fix}),
      .rd_buf   (rb_q),
      .rd_addr  (ridx_q),
      .rd_byte  (rd_byte)
   );

   // ---------------- readout ----------------
   logic [NUM_BUF-1:0] ready_q, ready_d;
   logic               rd_mid_q, go, rd_last;

   assign go      = rd_mid_q || ready_q[rb_q];
   assign rd_last = go && (ridx_q == LAST_IDX);

   always_comb begin
      ready_d = ready_q;
      if (rd_last) ready_d[rb_q] = 1'b0;
      if (cell_end && class_q == CLS_PASS) ready_d[wb_q] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= '0;
         rd_mid_q <= 1'b0;
         rb_q     <= '0;
         ridx_q   <= '0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         wr_sop   <= 1'b0;
         wr_eop   <= 1'b0;
         cnt_good <= '0;
      end else begin
         ready_q <= ready_d;
         wr_en   <= go;
         wr_data <= go ? rd_byte : 8'h00;
         wr_sop  <= go && (ridx_q == '0);
         wr_eop  <= rd_last;
         if (go) begin
            rd_mid_q <= !rd_last;
            ridx_q   <= rd_last ? '0 : ridx_q + 1'b1;
            if (rd_last) begin
               rb_q     <= ~rb_q;
               cnt_good <= cnt_good + 1'b1;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   AST_FIX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_end && !hdr_bad) |-> ((crc8_word(hdr_fix) ^ HEC_COSET) == hec_fix)); // R2

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |-> !ready_q[wb_q]); // R7

   AST_BURST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_eop) |=> (wr_en && !wr_sop)); // R5

   AST_SOP_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_eop) |=> (!wr_en || wr_sop)); // R5

   AST_GOOD_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_eop) |-> (cnt_good == $past(cnt_good) + 1'b1)); // R6

endmodule

// File: tb/tb_hec_cell_filter.sv
`timescale 1ns/1ps
module tb_hec_cell_filter;

   localparam int CB = 53;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        wr_en, wr_sop, wr_eop;
   logic [7:0]  wr_data;
   logic [15:0] cnt_good, cnt_err_drop, cnt_idle_drop;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   hec_cell_filter dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
      .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
      .cnt_good(cnt_good), .cnt_err_drop(cnt_err_drop), .cnt_idle_drop(cnt_idle_drop)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Bit-serial reference of the check byte (R1).
   function automatic logic [7:0] ref_hec(input logic [31:0] h);
      logic [7:0] c = 8'h00;
      logic fb;
      for (int i = 31; i >= 0; i--) begin
         fb = c[7] ^ h[i];
         c  = {c[6:0], 1'b0};
         if (fb) c = c ^ 8'h07;
      end
      return c ^ 8'h55;
   endfunction

   function automatic logic [7:0] pay(input int seed, input int i);
      return 8'((seed * 29 + i * 7 + 3) & 255);
   endfunction

   // ---------------- monitor ----------------
   logic [7:0] cap [16][CB];
   int n_cap   = 0;
   int cap_pos = 0;

   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         if (wr_sop) cap_pos = 0;
         if (cap_pos < CB) cap[n_cap % 16][cap_pos] = wr_data;
         if (wr_eop) begin
            chk(cap_pos == CB - 1, "R5 burst length", cap_pos + 1, CB);
            n_cap++;
         end
         cap_pos++;
      end
   end

   task automatic chk_cell(input int idx, input logic [31:0] h, input int seed, input string req);
      logic [39:0] hw;
      logic [7:0]  e;
      int bad = 0, a1 = 0, e1 = 0;
      hw = {h, ref_hec(h)};
      for (int i = 0; i < CB; i++) begin
         e = (i < 5) ? hw[39-8*i -: 8] : pay(seed, i);
         if (cap[idx % 16][i] !== e) begin
            if (bad == 0) begin a1 = int'(cap[idx % 16][i]); e1 = int'(e); end
            bad++;
         end
      end
      chk(bad == 0, req, a1, e1);
   endtask

   task automatic send_cell(input logic [31:0] h, input logic [39:0] flip, input int seed, input int nbytes);
      logic [39:0] hw;
      hw = {h, ref_hec(h)} ^ flip;
      for (int i = 0; i < nbytes; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (i == 0);
         in_data  = (i < 5) ? hw[39-8*i -: 8] : pay(seed, i);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(wr_en == 1'b0, "R6 wr_en in reset", int'(wr_en), 0);
      chk(cnt_good == 0, "R6 cnt_good reset", int'(cnt_good), 0);
      chk(cnt_err_drop == 0, "R6 cnt_err_drop reset", int'(cnt_err_drop), 0);
      chk(cnt_idle_drop == 0, "R6 cnt_idle_drop reset", int'(cnt_idle_drop), 0);
   endtask

   task automatic t_clean;
      int base = n_cap;
      int g0 = int'(cnt_good);
      send_cell(32'h1234_5670, 40'h0, 11, CB);
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      chk(wr_en == 1'b0, "R7 no early write", int'(wr_en), 0);
      @(negedge clk);
      chk(wr_en && wr_sop, "R7 first byte one clock after last", int'(wr_en && wr_sop), 1);
      repeat (60) @(negedge clk);
      chk(n_cap == base + 1, "R1 clean cell forwarded", n_cap - base, 1);
      chk_cell(base, 32'h1234_5670, 11, "R1 clean cell content");
      chk(int'(cnt_good) == g0 + 1, "R6 cnt_good increment", int'(cnt_good), g0 + 1);
   endtask

   task automatic t_single;
      int g0 = int'(cnt_good);
      for (int p = 0; p < 40; p++) begin
         int base = n_cap;
         send_cell(32'hA5C3_0F90, 40'h1 << p, p + 20, CB);
         idle(60);
         if (n_cap == base + 1) chk_cell(base, 32'hA5C3_0F90, p + 20, "R2 single-bit repair");
         else chk(1'b0, "R2 single-bit cell missing", n_cap - base, 1);
      end
      chk(int'(cnt_good) == g0 + 40, "R6 cnt_good after repairs", int'(cnt_good), g0 + 40);
   endtask

   task automatic t_double;
      int pa [3] = '{0, 8, 17};
      int pb [3] = '{1, 39, 30};
      for (int k = 0; k < 3; k++) begin
         int base = n_cap;
         int e0 = int'(cnt_err_drop);
         int g0 = int'(cnt_good);
         send_cell(32'h0BAD_CE11, (40'h1 << pa[k]) | (40'h1 << pb[k]), 70 + k, CB);
         idle(60);
         chk(n_cap == base, "R3 errored cell not written", n_cap - base, 0);
         chk(int'(cnt_err_drop) == e0 + 1, "R3 cnt_err_drop", int'(cnt_err_drop), e0 + 1);
         chk(int'(cnt_good) == g0, "R3 cnt_good unchanged", int'(cnt_good), g0);
      end
   endtask

   task automatic t_idle;
      int base = n_cap;
      int i0 = int'(cnt_idle_drop);
      send_cell(32'h0000_0001, 40'h0, 5, CB);
      idle(60);
      chk(n_cap == base, "R4 idle cell not written", n_cap - base, 0);
      chk(int'(cnt_idle_drop) == i0 + 1, "R4 cnt_idle_drop", int'(cnt_idle_drop), i0 + 1);
      send_cell(32'h0000_0001, 40'h1 << 9, 6, CB);
      idle(60);
      chk(n_cap == base, "R4 repaired idle not written", n_cap - base, 0);
      chk(int'(cnt_idle_drop) == i0 + 2, "R4 repaired idle counted", int'(cnt_idle_drop), i0 + 2);
      send_cell(32'h0000_0003, 40'h0, 7, CB);
      idle(60);
      chk(n_cap == base + 1, "R4 near-idle header forwarded", n_cap - base, 1);
      chk_cell(base, 32'h0000_0003, 7, "R4 near-idle content");
   endtask

   task automatic t_trunc;
      int base = n_cap;
      int e0 = int'(cnt_err_drop);
      int i0 = int'(cnt_idle_drop);
      int g0 = int'(cnt_good);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = 1'b0;
         in_data  = 8'hA5;
      end
      idle(60);
      chk(n_cap == base, "R8 stray bytes ignored", n_cap - base, 0);
      send_cell(32'h7777_1230, 40'h0, 40, 20);
      send_cell(32'h3141_5920, 40'h0, 41, CB);
      idle(80);
      chk(n_cap == base + 1, "R8 truncated cell dropped", n_cap - base, 1);
      if (n_cap == base + 1) chk_cell(base, 32'h3141_5920, 41, "R8 following cell intact");
      chk(int'(cnt_err_drop) == e0 && int'(cnt_idle_drop) == i0, "R8 drop counters unchanged",
          int'(cnt_err_drop) + int'(cnt_idle_drop), e0 + i0);
      chk(int'(cnt_good) == g0 + 1, "R8 cnt_good one cell", int'(cnt_good), g0 + 1);
   endtask

   task automatic t_b2b;
      int base = n_cap;
      int g0 = int'(cnt_good);
      for (int k = 0; k < 4; k++) send_cell(32'h1000_0000 + 32'(k * 32'h0101_0100), 40'h0, 90 + k, CB);
      idle(300);
      chk(n_cap == base + 4, "R5 back-to-back count", n_cap - base, 4);
      for (int k = 0; k < 4; k++) chk_cell(base + k, 32'h1000_0000 + 32'(k * 32'h0101_0100), 90 + k, "R5 back-to-back order/content");
      chk(int'(cnt_good) == g0 + 4, "R6 cnt_good back-to-back", int'(cnt_good), g0 + 4);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_clean();
      t_single();
      t_double();
      t_idle();
      t_trunc();
      t_b2b();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule